// File: doc/BRIEF.md
# Isolated Link Power-State Controller

This block decides when one end of a two-wire isolated SPI link is asleep, waking or awake. One input picks master or slave behaviour. A slave wakes only on line activity that the analog front end reports and that stays asserted long enough to be more than noise. A master wakes on a falling edge of its local chip-select. In both modes a fixed settling delay follows the wake trigger. Bias enable rises at the start of that delay. When the delay ends the block enters its awake states. A master then asks the pulse transmitter for a long wake pulse. The pulse polarity follows the chip-select level at that moment.

An inactivity counter returns the link to its low-power state. Any activity, transmitter busy, chip-select edge or forced-awake level restarts this counter. A master whose chip-select is low never times out. While a slave is asleep, its local SPI outputs are held at fixed safe levels. While it is awake, the decoded SPI lines pass through. A slave also blocks data pulses to the link whenever its local device drives data-out high, so a slave that is not addressed keeps quiet on a shared cable. Every duration is set in nanoseconds and turned into clock cycles from a clock-frequency parameter. Chip-select, enable and activity each pass through a two-stage synchronizer.

Top module: `lnk_pwr_ctl`

## Requirements
- R1: Reset puts the block in the idle state (state_o = 0) with bias_en_o = 0, wake_req_o = 0, tx_gate_o = 0, spi_cs_n_o = 1, spi_mosi_o = 1 and spi_sck_o = cpol_i.
- R2: A slave in idle starts waking only when line_act_i stays high for at least FILT_NS worth of cycles without a break. A shorter assertion leaves state_o at 0 and bias_en_o at 0.
- R3: After a wake trigger, state_o = 1 (waking) and bias_en_o = 1 for READY_NS worth of cycles. Then state_o becomes 2 (ready) or 3 (active), and never goes straight back to 0.
- R4: An awake slave with no activity, no transmitter busy and enable low returns to state_o = 0 with bias_en_o = 0 after IDLE_NS worth of cycles.
- R5: For a slave, while state_o is 0, the outputs are spi_cs_n_o = 1, spi_mosi_o = 1 and spi_sck_o = cpol_i. While awake, these outputs follow rx_cs_n_i, rx_mosi_i and rx_sck_i.
- R6: A master ignores line_act_i in idle. It starts waking on a falling edge of cs_n_i. A slave never raises wake_req_o.
- R7: When the settling delay of a master ends with cs_n_i high, exactly one one-cycle wake_req_o pulse is issued, with wake_pol_o = 1 (positive).
- R8: When the settling delay of a master ends with cs_n_i low, a pulse with wake_pol_o = 0 is issued at once. A second pulse with wake_pol_o = 1 follows when cs_n_i returns high.
- R9: A master stays awake for as long as cs_n_i is low, however long that lasts. After cs_n_i rises with enable low, it returns to idle only once IDLE_NS worth of cycles pass.
- R10: With force_awake_i high, either mode leaves idle and never returns to state_o = 0 while it stays high.
- R11: For a slave, tx_gate_o = 0 while sdo_i = 1 or while idle, and tx_gate_o = 1 while awake with sdo_i = 0. For a master, tx_gate_o = 1 whenever it is awake.
- R12: Line activity, transmitter busy or a chip-select edge while awake restarts the full idle timeout.
- R13: While awake, state_o = 3 (active) when tx_busy_i or the synchronized activity is high, and state_o = 2 (ready) otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_master_i | input | 1 | 1 = master end, 0 = slave end |
| force_awake_i | input | 1 | Asynchronous; high keeps the link awake |
| cs_n_i | input | 1 | Asynchronous local chip-select (master end) |
| line_act_i | input | 1 | Asynchronous differential activity from comparator |
| tx_busy_i | input | 1 | Pulse transmitter is sending |
| sdo_i | input | 1 | Local SPI device data-out (slave end) |
| cpol_i | input | 1 | Configured idle clock level |
| rx_cs_n_i | input | 1 | Decoded chip-select from pulse receiver |
| rx_mosi_i | input | 1 | Decoded data from pulse receiver |
| rx_sck_i | input | 1 | Decoded clock from pulse receiver |
| bias_en_o | output | 1 | Enable for bias circuitry |
| wake_req_o | output | 1 | One-cycle request for a long wake pulse |
| wake_pol_o | output | 1 | Wake pulse polarity, 1 = positive |
| tx_gate_o | output | 1 | Data pulses to the link are allowed |
| spi_cs_n_o | output | 1 | Local SPI chip-select out |
| spi_mosi_o | output | 1 | Local SPI data out |
| spi_sck_o | output | 1 | Local SPI clock out |
| state_o | output | 2 | 0 idle, 1 waking, 2 ready, 3 active |

## Verification
The hardest situation to reach is a master whose chip-select is still low when the settling delay ends. Only this case leads to the two-pulse sequence, and it overlaps with the rule that a held-low chip-select stops the idle timeout. The bench reaches it by holding chip-select low from the falling edge until well past both the settling delay and a full idle period. Then it releases chip-select. It checks the negative pulse, then the positive pulse, and then the delayed return to idle. The noise filter boundary is approached from both sides with activity pulses one cycle shorter than the filter length and exactly as long as it.

// File: rtl/lnk_pwr_pkg.sv
package lnk_pwr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WAKE   = 2'd1,
    ST_READY  = 2'd2,
    ST_ACTIVE = 2'd3
  } lnk_state_e;

  // Cycles covering a duration, rounded up, at least one.
  function automatic int ns_to_cyc(longint hz, longint ns);
    longint c;
    c = ((hz / 1000) * ns + 999_999) / 1_000_000;
    if (c < 1) c = 1;
    return int'(c);
  endfunction

endpackage

// File: rtl/lnk_sync.sv
module lnk_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1 <= RST_VAL[i];
        s2 <= RST_VAL[i];
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end

endmodule

// File: rtl/lnk_tmr.sv
module lnk_tmr #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic done
);

  localparam int W = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (en && cnt != LAST) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign done = en && !clr && (cnt == LAST);

endmodule

// File: rtl/lnk_pwr_ctl.sv
module lnk_pwr_ctl
  import lnk_pwr_pkg::*;
#(
  parameter longint CLK_HZ   = 250_000_000,
  parameter longint IDLE_NS  = 5_700_000,
  parameter longint READY_NS = 8_000,
  parameter longint FILT_NS  = 240
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       mode_master_i,
  input  logic       force_awake_i,
  input  logic       cs_n_i,
  input  logic       line_act_i,
  input  logic       tx_busy_i,
  input  logic       sdo_i,
  input  logic       cpol_i,
  input  logic       rx_cs_n_i,
  input  logic       rx_mosi_i,
  input  logic       rx_sck_i,
  output logic       bias_en_o,
  output logic       wake_req_o,
  output logic       wake_pol_o,
  output logic       tx_gate_o,
  output logic       spi_cs_n_o,
  output logic       spi_mosi_o,
  output logic       spi_sck_o,
  output logic [1:0] state_o
);

  localparam int IDLE_CYC  = ns_to_cyc(CLK_HZ, IDLE_NS);
  localparam int READY_CYC = ns_to_cyc(CLK_HZ, READY_NS);
  localparam int FILT_CYC  = ns_to_cyc(CLK_HZ, FILT_NS);

  // Synchronized asynchronous inputs
  logic cs_s, en_s, act_s, cs_d;

  lnk_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({cs_n_i, force_awake_i, line_act_i}),
    .q   ({cs_s, en_s, act_s})
  );

  always_ff @(posedge clk) begin
    if (rst) cs_d <= 1'b1;
    else     cs_d <= cs_s;
  end

  logic cs_fall, cs_rise, cs_edge;
  assign cs_fall = cs_d && !cs_s;
  assign cs_rise = !cs_d && cs_s;
  assign cs_edge = cs_fall || cs_rise;

  lnk_state_e st, nxt;
  logic awake;
  assign awake = (st == ST_READY) || (st == ST_ACTIVE);

  // Activity noise filter: consecutive high cycles
  logic filt_ok;
  lnk_tmr #(.LIMIT(FILT_CYC)) u_filt (
    .clk  (clk),
    .rst  (rst),
    .clr  (!act_s),
    .en   (act_s),
    .done (filt_ok)
  );

  // Bias settling delay
  logic rdy_done;
  lnk_tmr #(.LIMIT(READY_CYC)) u_rdy (
    .clk  (clk),
    .rst  (rst),
    .clr  (st != ST_WAKE),
    .en   (st == ST_WAKE),
    .done (rdy_done)
  );

  // Inactivity timeout
  logic restart, idle_done, hold;
  assign restart = act_s || tx_busy_i || cs_edge || en_s;
  assign hold    = en_s || (mode_master_i && !cs_s);

  lnk_tmr #(.LIMIT(IDLE_CYC)) u_idle (
    .clk  (clk),
    .rst  (rst),
    .clr  (!awake || restart),
    .en   (awake),
    .done (idle_done)
  );

  logic wake_trig, busy;
  assign wake_trig = en_s || (mode_master_i ? cs_fall : filt_ok);
  assign busy      = tx_busy_i || act_s;

  always_comb begin
    nxt = st;
    unique case (st)
      ST_IDLE: if (wake_trig) nxt = ST_WAKE;
      ST_WAKE: if (rdy_done)  nxt = busy ? ST_ACTIVE : ST_READY;
      default: begin
        if (idle_done && !hold) nxt = ST_IDLE;
        else                    nxt = busy ? ST_ACTIVE : ST_READY;
      end
    endcase
  end

  logic pend_pos, park;
  assign park = !mode_master_i && (st == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      bias_en_o  <= 1'b0;
      wake_req_o <= 1'b0;
      wake_pol_o <= 1'b0;
      pend_pos   <= 1'b0;
      tx_gate_o  <= 1'b0;
      spi_cs_n_o <= 1'b1;
      spi_mosi_o <= 1'b1;
      spi_sck_o  <= cpol_i;
    end else begin
      st         <= nxt;
      bias_en_o  <= (nxt != ST_IDLE);
      wake_req_o <= 1'b0;
      if (mode_master_i && st == ST_WAKE && rdy_done) begin
        wake_req_o <= 1'b1;
        wake_pol_o <= cs_s;
        pend_pos   <= !cs_s;
      end else if (mode_master_i && pend_pos && awake && cs_rise) begin
        wake_req_o <= 1'b1;
        wake_pol_o <= 1'b1;
        pend_pos   <= 1'b0;
      end else if (nxt == ST_IDLE) begin
        pend_pos   <= 1'b0;
      end
      tx_gate_o  <= (nxt == ST_READY || nxt == ST_ACTIVE) &&
                    (mode_master_i || !sdo_i);
      spi_cs_n_o <= park ? 1'b1   : rx_cs_n_i;
      spi_mosi_o <= park ? 1'b1   : rx_mosi_i;
      spi_sck_o  <= park ? cpol_i : rx_sck_i;
    end
  end

  assign state_o = st;

  AST_PULSE_NEEDS_BIAS: assert property (@(posedge clk) disable iff (rst)
    wake_req_o |-> bias_en_o); // R7
  AST_PULSE_MASTER_ONLY: assert property (@(posedge clk) disable iff (rst)
    wake_req_o |-> $past(mode_master_i)); // R6
  AST_EN_KEEPS_AWAKE: assert property (@(posedge clk) disable iff (rst)
    (en_s && st != ST_IDLE) |=> (st != ST_IDLE)); // R10
  AST_CS_LOW_KEEPS_AWAKE: assert property (@(posedge clk) disable iff (rst)
    (mode_master_i && !cs_s && awake) |=> (st != ST_IDLE)); // R9
  AST_WAKE_NOT_BACK_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAKE) |=> (st != ST_IDLE)); // R3
  AST_SLAVE_PARKED: assert property (@(posedge clk) disable iff (rst)
    (!$past(mode_master_i) && $past(st) == ST_IDLE) |-> (spi_cs_n_o && spi_mosi_o)); // R5
  AST_GATE_BLOCKED_BY_SDO: assert property (@(posedge clk) disable iff (rst)
    (!$past(mode_master_i) && $past(sdo_i)) |-> !tx_gate_o); // R11
  AST_IDLE_AFTER_TIMEOUT: assert property (@(posedge clk) disable iff (rst)
    ($past(awake) && st == ST_IDLE) |-> $past(idle_done)); // R4

endmodule

// File: tb/lnk_pwr_ctl_tb.sv
`timescale 1ns/1ps
module lnk_pwr_ctl_tb;

  localparam int FILT = 10;
  localparam int RDY  = 50;
  localparam int IDL  = 1000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_master = 1'b0, force_awake = 1'b0, cs_n = 1'b1, line_act = 1'b0;
  logic tx_busy = 1'b0, sdo = 1'b1, cpol = 1'b0;
  logic rx_cs_n = 1'b1, rx_mosi = 1'b1, rx_sck = 1'b0;
  logic bias_en, wake_req, wake_pol, tx_gate, spi_cs_n, spi_mosi, spi_sck;
  logic [1:0] state;

  always #2 clk = ~clk;

  lnk_pwr_ctl #(
    .CLK_HZ(250_000_000), .IDLE_NS(4000), .READY_NS(200), .FILT_NS(40)
  ) u_dut (
    .clk(clk), .rst(rst), .mode_master_i(mode_master), .force_awake_i(force_awake),
    .cs_n_i(cs_n), .line_act_i(line_act), .tx_busy_i(tx_busy), .sdo_i(sdo),
    .cpol_i(cpol), .rx_cs_n_i(rx_cs_n), .rx_mosi_i(rx_mosi), .rx_sck_i(rx_sck),
    .bias_en_o(bias_en), .wake_req_o(wake_req), .wake_pol_o(wake_pol),
    .tx_gate_o(tx_gate), .spi_cs_n_o(spi_cs_n), .spi_mosi_o(spi_mosi),
    .spi_sck_o(spi_sck), .state_o(state)
  );

  int checks = 0;
  int failures = 0;
  int npulse = 0;
  logic last_pol = 1'b0;
  logic finished = 1'b0;

  always @(posedge clk) begin
    if (wake_req) begin
      npulse   <= npulse + 1;
      last_pol <= wake_pol;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(logic master);
    @(negedge clk);
    rst = 1'b1; mode_master = master; force_awake = 1'b0; cs_n = 1'b1;
    line_act = 1'b0; tx_busy = 1'b0; sdo = 1'b1;
    wc(4);
    rst = 1'b0;
    wc(2);
  endtask

  task automatic act_pulse(int len);
    line_act = 1'b1;
    wc(len);
    line_act = 1'b0;
  endtask

  // Filter table: activity length, expected wake
  localparam int NV = 6;
  localparam int V_LEN [NV] = '{2, 7, 9, 10, 14, 30};
  localparam int V_EXP [NV] = '{0, 0, 0, 1, 1, 1};

  initial begin
    int base;
    // R1 reset state
    do_reset(1'b0);
    check("R1 state", state, 0);
    check("R1 bias", bias_en, 0);
    check("R1 wake_req", wake_req, 0);
    check("R1 gate", tx_gate, 0);
    check("R1 cs_n", spi_cs_n, 1);
    check("R1 mosi", spi_mosi, 1);
    check("R1 sck", spi_sck, 0);

    // R2 filter boundary table
    for (int i = 0; i < NV; i++) begin
      do_reset(1'b0);
      act_pulse(V_LEN[i]);
      wc(30);
      check("R2 woke", int'(state != 2'd0), V_EXP[i]);
      check("R2 bias", bias_en, V_EXP[i]);
    end

    // R3 ready delay, R4 timeout, R5 parking, R11 gate, R13 active
    do_reset(1'b0);
    cpol = 1'b1; rx_cs_n = 1'b0; rx_mosi = 1'b0; rx_sck = 1'b0;
    wc(3);
    check("R5 sck parked at cpol", spi_sck, 1);
    act_pulse(14);
    wc(44);
    check("R3 waking state", state, 1);
    check("R3 bias during wait", bias_en, 1);
    wc(10);
    check("R3 ready after delay", state, 2);
    check("R5 cs pass-through", spi_cs_n, 0);
    check("R5 mosi pass-through", spi_mosi, 0);
    check("R11 gate blocked sdo high", tx_gate, 0);
    sdo = 1'b0;
    wc(3);
    check("R11 gate open sdo low", tx_gate, 1);
    tx_busy = 1'b1;
    wc(3);
    check("R13 active on busy", state, 3);
    tx_busy = 1'b0;
    wc(3);
    check("R13 ready after busy", state, 2);
    wc(IDL - 30);
    check("R4 still awake before timeout", int'(state != 2'd0), 1);
    wc(50);
    check("R4 idle after timeout", state, 0);
    check("R4 bias off", bias_en, 0);
    check("R11 gate closed idle", tx_gate, 0);
    check("R5 cs parked", spi_cs_n, 1);
    check("R5 mosi parked", spi_mosi, 1);
    check("R5 sck parked", spi_sck, 1);
    cpol = 1'b0; rx_cs_n = 1'b1; rx_mosi = 1'b1;

    // R12 restart by activity
    do_reset(1'b0);
    act_pulse(14);
    wc(500);
    act_pulse(3);
    base = 0;
    wc(IDL - 400);
    check("R12 restarted timeout keeps awake", int'(state != 2'd0), 1);
    wc(460);
    check("R12 idle after restarted timeout", state, 0);

    // R10 enable forces awake
    do_reset(1'b0);
    force_awake = 1'b1;
    wc(100);
    check("R10 woke on enable", int'(state >= 2'd2), 1);
    wc(2500);
    check("R10 stays awake", int'(state != 2'd0), 1);
    force_awake = 1'b0;
    wc(IDL + 60);
    check("R10 idle after enable drop", state, 0);

    // R6 master ignores activity
    do_reset(1'b1);
    base = npulse;
    act_pulse(40);
    wc(100);
    check("R6 master ignores activity", state, 0);
    check("R6 no pulse", npulse - base, 0);

    // R7 cs high at end of delay
    cs_n = 1'b0;
    wc(5);
    check("R6 wake on cs fall", state, 1);
    cs_n = 1'b1;
    wc(100);
    check("R7 one pulse", npulse - base, 1);
    check("R7 positive polarity", last_pol, 1);
    check("R11 master gate open", tx_gate, 1);
    wc(IDL + 60);
    check("R9 master idle after timeout", state, 0);

    // R8 / R9 cs held low
    do_reset(1'b1);
    base = npulse;
    cs_n = 1'b0;
    wc(100);
    check("R8 first pulse", npulse - base, 1);
    check("R8 negative polarity", last_pol, 0);
    wc(1500);
    check("R9 awake while cs low", int'(state != 2'd0), 1);
    check("R8 no second pulse yet", npulse - base, 1);
    cs_n = 1'b1;
    wc(10);
    check("R8 second pulse", npulse - base, 2);
    check("R8 second positive", last_pol, 1);
    wc(IDL - 40);
    check("R9 held off between packets", int'(state != 2'd0), 1);
    wc(60);
    check("R9 idle after cs high timeout", state, 0);

    // R6 slave never requests pulses
    do_reset(1'b0);
    base = npulse;
    act_pulse(20);
    wc(100);
    check("R6 slave no pulse", npulse - base, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule